// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave

This block is the device side of a four-wire serial bus that fronts a byte-wide internal memory. A host selects it by pulling the active-low select low. It then shifts in an 8-bit command and, for memory commands, a 16-bit address. After that, data bytes stream into or out of the array. All fields travel most significant bit first. Every serial pin is sampled in the system clock domain, so the serial clock must run well below the system clock.

A mode register sets how the internal address pointer moves after each data byte. Its bits 7:6 select one of three modes. In single-byte mode the pointer does not move and only one byte is transferred. In page mode the pointer advances inside a 32-byte page and wraps to the start of that same page. In sequential mode it advances across the whole array and rolls over from the last byte to byte zero. An active-low pause input freezes the transfer at its current bit and releases the data output. The select input keeps working while the transfer is paused.

The array holds 2**ADDR_W bytes. ADDR_W = 15 gives the full 32,768-byte array. Address bits above ADDR_W are ignored, so in the full array the address MSB is ignored. The default ADDR_W is kept smaller so that the array stays small when elaborated. Read data leaves on the `so` pin and `so_oe` tells the pad when to drive it. The serial link has no back-pressure: every clock pulse moves a bit, and the host paces the transfer only through its clock, the pause input and the select input.

Top module: `spi_sram_slave`

## Requirements
- R1: After reset the mode register reads 0x00 and `so_oe` is low.
- R2: Command 0x02 followed by a 16-bit address (only its low ADDR_W bits are used) stores the next 8 bits at that address. In mode 00, any further data bytes in the same selection are ignored.
- R3: Command 0x03 returns the addressed byte on `so`. Each bit changes only on a falling serial-clock edge, starting with the falling edge after the last address bit. In mode 00, `so_oe` drops after the first byte.
- R4: Command 0x01 writes the next byte into the mode register. Command 0x05 reads that register back, and the value repeats for as long as the clock runs.
- R5: Mode bits 7:6 = 10 (page mode) step the pointer through the 32-byte page and wrap from the last byte of the page to its first byte. This holds for both reads and writes.
- R6: Mode bits 7:6 = 01 (sequential mode) step the pointer by one after every byte and roll it over from the highest address to 0.
- R7: Mode bits 7:6 = 11 behave exactly like 00.
- R8: Raising select before the 8th bit of a write byte discards that partial byte, and memory is unchanged.
- R9: While the pause input is low, clock and data activity has no effect and `so_oe` is low. When the pause input returns high, shifting resumes at the bit where it stopped.
- R10: Any command other than 0x01, 0x02, 0x03 or 0x05 causes the rest of the selection to be ignored. In that case `so_oe` stays low and neither memory nor the mode register changes.
- R11: `so_oe` is low whenever select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select; a rising edge ends the transfer |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in, sampled on rising `sck` |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out, updated on falling `sck` |
| so_oe | output | 1 | Output enable for `so` |

## Verification
The assertions take for granted that each serial-clock phase spans several system clocks. This lets every rising and falling edge be seen once, after synchronisation, and lets `si` settle before the edge that samples it. They also assume that the pause input and select change only while the serial clock is low. The bench meets both conditions by holding every serial phase for eight system clocks and by moving select and the pause input only between bits, with the clock low. The mode register is written only in its own selection, so the pointer-stepping checks see one mode for the whole of a data burst.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;

  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_MODEW = 8'h01;
  localparam logic [7:0] OP_MODER = 8'h05;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_SEQ  = 2'd1,
    STEP_PAGE = 2'd2
  } step_e;

  typedef enum logic [3:0] {
    ST_CMD,
    ST_ADDR,
    ST_WR,
    ST_RD,
    ST_MODEW,
    ST_MODER,
    ST_SKIP,
    ST_DONE
  } fsm_e;

  function automatic step_e step_of(input logic [1:0] bits);
    case (bits)
      2'b01:   return STEP_SEQ;
      2'b10:   return STEP_PAGE;
      default: return STEP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic sel,
  output logic hold_ok,
  output logic si_s,
  output logic sck_rise,
  output logic sck_fall
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] cs_pipe, hold_pipe, sck_pipe, si_pipe;
  logic          sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe   <= '1;
      hold_pipe <= '1;
      sck_pipe  <= '0;
      si_pipe   <= '0;
      sck_prev  <= 1'b0;
    end else begin
      cs_pipe   <= {cs_pipe[LAST-1:0], cs_n};
      hold_pipe <= {hold_pipe[LAST-1:0], hold_n};
      sck_pipe  <= {sck_pipe[LAST-1:0], sck};
      si_pipe   <= {si_pipe[LAST-1:0], si};
      sck_prev  <= sck_pipe[LAST];
    end
  end

  assign sel      = ~cs_pipe[LAST];
  assign hold_ok  = hold_pipe[LAST];
  assign si_s     = si_pipe[LAST];
  assign sck_rise = sel & hold_ok &  sck_pipe[LAST] & ~sck_prev;
  assign sck_fall = sel & hold_ok & ~sck_pipe[LAST] &  sck_prev;

endmodule

// File: rtl/sram_addr_step.sv
module sram_addr_step
  import sram_spi_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  step_e              step,
  input  logic [ADDR_W-1:0]  addr,
  output logic [ADDR_W-1:0]  addr_nxt
);
  logic [ADDR_W-1:0] page_nxt;

  generate
    if (PAGE_W >= ADDR_W) begin : g_page_is_array
      assign page_nxt = addr + 1'b1;
    end else begin : g_page_split
      logic [PAGE_W-1:0] low_nxt;
      assign low_nxt  = addr[PAGE_W-1:0] + 1'b1;
      assign page_nxt = {addr[ADDR_W-1:PAGE_W], low_nxt};
    end
  endgenerate

  always_comb begin
    case (step)
      STEP_SEQ:  addr_nxt = addr + 1'b1;
      STEP_PAGE: addr_nxt = page_nxt;
      default:   addr_nxt = addr;
    endcase
  end

endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/spi_sram_slave.sv
module spi_sram_slave
  import sram_spi_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  logic              sel, hold_ok, si_s, sck_rise, sck_fall;
  fsm_e              state;
  logic [3:0]        bit_cnt;
  logic [2:0]        fall_cnt;
  logic [14:0]       shreg;
  logic [7:0]        opcode_q;
  logic [7:0]        status_q;
  logic [ADDR_W-1:0] ptr, ptr_nxt;
  logic [7:0]        tx_q;
  logic              so_q, drive_q;
  logic [7:0]        rx_byte;
  logic [15:0]       rx_word;
  logic              mem_we;
  logic [7:0]        mem_rdata, src_byte;
  logic              byte_end;
  step_e             step;

  spi_pin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .sel(sel), .hold_ok(hold_ok), .si_s(si_s), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  assign step = step_of(status_q[7:6]);

  sram_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
    .step(step), .addr(ptr), .addr_nxt(ptr_nxt)
  );

  assign rx_byte  = {shreg[6:0], si_s};
  assign rx_word  = {shreg, si_s};
  assign byte_end = (bit_cnt[2:0] == 3'd7);
  assign mem_we   = sck_rise && (state == ST_WR) && byte_end;

  sram_byte_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(ptr), .wdata(rx_byte),
    .raddr(ptr), .rdata(mem_rdata)
  );

  assign src_byte = (state == ST_MODER) ? status_q : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_CMD;
      bit_cnt  <= '0;
      fall_cnt <= '0;
      shreg    <= '0;
      opcode_q <= '0;
      status_q <= '0;
      ptr      <= '0;
      tx_q     <= '0;
      so_q     <= 1'b0;
      drive_q  <= 1'b0;
    end else if (!sel) begin
      state    <= ST_CMD;
      bit_cnt  <= '0;
      fall_cnt <= '0;
      drive_q  <= 1'b0;
    end else begin
      if (sck_rise) begin
        shreg   <= rx_word[14:0];
        bit_cnt <= bit_cnt + 1'b1;
        case (state)
          ST_CMD: if (byte_end) begin
            bit_cnt  <= '0;
            fall_cnt <= '0;
            opcode_q <= rx_byte;
            case (rx_byte)
              OP_READ, OP_WRITE: state <= ST_ADDR;
              OP_MODER:          state <= ST_MODER;
              OP_MODEW:          state <= ST_MODEW;
              default:           state <= ST_SKIP;
            endcase
          end
          ST_ADDR: if (bit_cnt == 4'd15) begin
            bit_cnt  <= '0;
            fall_cnt <= '0;
            ptr      <= rx_word[ADDR_W-1:0];
            state    <= (opcode_q == OP_READ) ? ST_RD : ST_WR;
          end
          ST_WR, ST_RD: if (byte_end) begin
            bit_cnt <= '0;
            if (step == STEP_NONE) state <= ST_DONE;
            else                   ptr   <= ptr_nxt;
          end
          ST_MODEW: if (byte_end) begin
            status_q <= rx_byte;
            state    <= ST_DONE;
          end
          ST_MODER: if (byte_end) bit_cnt <= '0;
          default: ;
        endcase
      end
      if (sck_fall) begin
        if (state == ST_RD || state == ST_MODER) begin
          drive_q  <= 1'b1;
          fall_cnt <= fall_cnt + 1'b1;
          if (fall_cnt == 3'd0) begin
            so_q <= src_byte[7];
            tx_q <= {src_byte[6:0], 1'b0};
          end else begin
            so_q <= tx_q[7];
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end else begin
          drive_q <= 1'b0;
        end
      end
    end
  end

  assign so    = so_q;
  assign so_oe = ~cs_n & hold_n & drive_q;

endmodule

// File: rtl/sram_spi_chk.sv
module sram_spi_chk #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sel,
  input logic              hold_ok,
  input logic              sck_fall,
  input logic              so_oe,
  input logic              so_q,
  input logic [3:0]        bit_cnt,
  input logic [ADDR_W-1:0] ptr,
  input logic              mem_we,
  input logic [1:0]        mode_bits
);
  logic [1:0]        wr_seen;
  logic [ADDR_W-1:0] last_wa;
  logic [ADDR_W-1:0] exp_page, exp_seq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen <= '0;
      last_wa <= '0;
    end else if (!sel) begin
      wr_seen <= '0;
    end else if (mem_we) begin
      if (wr_seen != 2'd3) wr_seen <= wr_seen + 1'b1;
      last_wa <= ptr;
    end
  end

  assign exp_seq = last_wa + 1'b1;
  always_comb begin
    exp_page = last_wa;
    exp_page[PAGE_W-1:0] = last_wa[PAGE_W-1:0] + 1'b1;
  end

  p_oe_off_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so_oe);

  p_so_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so_q) |-> $past(sck_fall));

  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !hold_ok) |=> ($stable(bit_cnt) && $stable(ptr)));

  p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mode_bits == 2'b00 || mode_bits == 2'b11)) |-> (wr_seen == 2'd0));

  p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mode_bits == 2'b10 && wr_seen != 2'd0) |-> (ptr == exp_page));

  p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mode_bits == 2'b01 && wr_seen != 2'd0) |-> (ptr == exp_seq));

  p_no_write_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> sel);

endmodule

bind spi_sram_slave sram_spi_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sel(sel), .hold_ok(hold_ok),
  .sck_fall(sck_fall), .so_oe(so_oe), .so_q(so_q), .bit_cnt(bit_cnt),
  .ptr(ptr), .mem_we(mem_we), .mode_bits(status_q[7:6])
);

// File: tb/tb_spi_sram_slave.sv
module tb_spi_sram_slave;
  localparam int AW   = 8;
  localparam int SIZE = 1 << AW;
  localparam int H    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;
  int tests = 0, fails = 0;
  logic [7:0] em [SIZE];
  bit done = 0;

  always #2 clk = ~clk;

  spi_sram_slave #(.ADDR_W(AW), .PAGE_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .so(so), .so_oe(so_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bits(input logic [7:0] tx, input int hi, input int lo,
                      inout logic [7:0] rx, inout bit oe_all);
    for (int i = hi; i >= lo; i--) begin
      @(negedge clk) si = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = so;
      oe_all &= so_oe;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe_all);
    logic [7:0] r = '0;
    bit o = 1;
    bits(tx, 7, 0, r, o);
    rx = r;
    oe_all = o;
  endtask

  task automatic cs_lo();
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk(so_oe == 1'b0, "R11 oe after deselect", so_oe, 0);
    repeat (H) @(negedge clk);
  endtask

  task automatic start(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] r;
    bit o;
    cs_lo();
    xfer(op, r, o);
    xfer(a[15:8], r, o);
    xfer(a[7:0], r, o);
  endtask

  task automatic set_mode(input logic [7:0] v);
    logic [7:0] r;
    bit o;
    cs_lo();
    xfer(8'h01, r, o);
    xfer(v, r, o);
    cs_hi();
  endtask

  task automatic get_mode(output logic [7:0] v, output bit o);
    logic [7:0] r;
    bit oo;
    cs_lo();
    xfer(8'h05, r, oo);
    xfer(8'h00, v, o);
    cs_hi();
  endtask

  task automatic rd1(input logic [15:0] a, output logic [7:0] v);
    bit o;
    start(8'h03, a);
    xfer(8'h00, v, o);
    cs_hi();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, r;
    bit o;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(so_oe == 1'b0, "R1 oe at reset", so_oe, 0);
    get_mode(v, o);
    chk(v == 8'h00, "R1 mode reset value", v, 0);
    chk(o, "R3 oe during mode read", o, 1);

    // R4 mode round trip, enter sequential mode (01)
    set_mode(8'h40);
    get_mode(v, o);
    chk(v == 8'h40, "R4 mode readback", v, 8'h40);

    // R6 sequential fill of the whole array
    start(8'h02, 16'h0000);
    for (int a = 0; a < SIZE; a++) begin
      xfer(pat(a), r, o);
      em[a] = pat(a);
    end
    cs_hi();

    // R6 sequential read with rollover past the top address
    start(8'h03, 16'h00FC);
    for (int i = 0; i < SIZE + 4; i++) begin
      xfer(8'h00, r, o);
      chk(r == em[(252 + i) % SIZE], "R6 sequential data", r, em[(252 + i) % SIZE]);
      if (i == 3 || i == 4) chk(o, "R3 oe during data", o, 1);
    end
    cs_hi();

    // R2 byte mode write with upper address bits set, extra byte ignored
    set_mode(8'h00);
    start(8'h02, 16'hFF10);
    xfer(8'hA5, r, o);
    xfer(8'h3C, r, o);
    cs_hi();
    em[16] = 8'hA5;
    rd1(16'h0010, v);
    chk(v == 8'hA5, "R2 byte written", v, 8'hA5);
    rd1(16'h0011, v);
    chk(v == em[17], "R2 extra byte ignored", v, em[17]);

    // R3 byte mode read: second byte undriven
    start(8'h03, 16'h0020);
    xfer(8'h00, v, o);
    chk(v == em[32], "R3 read data", v, em[32]);
    xfer(8'h00, r, o);
    chk(!o, "R3 oe drops after byte", o, 0);
    cs_hi();

    // R5 page mode write wrapping inside page 0x20..0x3F
    set_mode(8'h80);
    start(8'h02, 16'h003E);
    xfer(8'h11, r, o);
    xfer(8'h22, r, o);
    xfer(8'h33, r, o);
    cs_hi();
    em[62] = 8'h11; em[63] = 8'h22; em[32] = 8'h33;
    start(8'h03, 16'h003F);
    xfer(8'h00, v, o);
    chk(v == 8'h22, "R5 page read first", v, 8'h22);
    xfer(8'h00, v, o);
    chk(v == 8'h33, "R5 page read wrapped", v, 8'h33);
    cs_hi();
    set_mode(8'h00);
    rd1(16'h0040, v);
    chk(v == em[64], "R5 next page untouched", v, em[64]);

    // R7 mode 11 acts as byte mode
    set_mode(8'hC0);
    start(8'h02, 16'h0050);
    xfer(8'h77, r, o);
    xfer(8'h88, r, o);
    cs_hi();
    em[80] = 8'h77;
    rd1(16'h0050, v);
    chk(v == 8'h77, "R7 first byte", v, 8'h77);
    rd1(16'h0051, v);
    chk(v == em[81], "R7 no advance", v, em[81]);

    // R8 partial byte discarded
    set_mode(8'h00);
    start(8'h02, 16'h0060);
    r = '0; o = 1;
    bits(8'hF0, 7, 4, r, o);
    cs_hi();
    rd1(16'h0060, v);
    chk(v == em[96], "R8 partial discarded", v, em[96]);

    // R9 pause during a read
    start(8'h03, 16'h0020);
    r = '0; o = 1;
    bits(8'h00, 7, 5, r, o);
    @(negedge clk) hold_n = 1'b0;
    repeat (H) @(negedge clk);
    chk(so_oe == 1'b0, "R9 oe off during pause", so_oe, 0);
    for (int k = 0; k < 4; k++) begin
      sck = 1'b1; si = k[0];
      repeat (H) @(negedge clk);
      sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    hold_n = 1'b1;
    bits(8'h00, 4, 0, r, o);
    chk(r == em[32], "R9 read resumes", r, em[32]);
    cs_hi();

    // R9 pause during a write
    start(8'h02, 16'h0070);
    r = '0; o = 1;
    bits(8'hC6, 7, 5, r, o);
    @(negedge clk) hold_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      sck = 1'b1; si = ~k[0];
      repeat (H) @(negedge clk);
      sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    hold_n = 1'b1;
    bits(8'hC6, 4, 0, r, o);
    cs_hi();
    em[112] = 8'hC6;
    rd1(16'h0070, v);
    chk(v == 8'hC6, "R9 write resumes", v, 8'hC6);

    // R10 unknown command ignored until deselect
    cs_lo();
    xfer(8'hAB, r, o);
    xfer(8'h02, r, o);
    chk(!o, "R10 oe stays low", o, 0);
    xfer(8'h00, r, o);
    xfer(8'h70, r, o);
    xfer(8'h99, r, o);
    cs_hi();
    rd1(16'h0070, v);
    chk(v == 8'hC6, "R10 memory unchanged", v, 8'hC6);
    get_mode(v, o);
    chk(v == 8'h00, "R10 mode unchanged", v, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule